// File: doc/BRIEF.md
# Frequency Meter and Event Counter

This block watches one conditioned digital input and produces two 32-bit result words for a command controller, which serializes them to the host. A measurement gate of `GATE_CYCLES` reference-clock cycles runs without pause. At the end of each gate both words are refreshed in the same cycle, and a one-cycle `res_valid` pulse marks the update.

The input passes through a two-flop synchronizer, and only its rising edges are counted. A mode input picks what the words carry.

- **Frequency mode** (`mode_count` = 0): the first word holds half the number of rising edges seen in the gate, so the host doubles it to recover the frequency. The second word holds the number of reference ticks in the gate.
- **Counter mode** (`mode_count` = 1): the first word holds a free-running event total, and the second word holds the same halved frequency reading.

The event total counts in both modes. It is cleared by `count_clear` and stops at its all-ones value instead of wrapping.

Top module: `edge_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_a`, `res_b` and `res_valid` all become 0.
- R2: `res_valid` is high for exactly one cycle in every `GATE_CYCLES` cycles.
- R3: With `mode_count` = 0 at the closing edge of a gate, `res_a` equals floor(E/2), where E is the number of rising input edges whose synchronized detection falls inside that gate.
- R4: With `mode_count` = 0 at the closing edge of a gate, `res_b` equals `GATE_CYCLES`, the reference ticks counted in the gate.
- R5: With `mode_count` = 1 at the closing edge of a gate, `res_a` equals the event total and `res_b` equals floor(E/2) for that gate.
- R6: A cycle with `count_clear` = 1 sets the event total to 0, and a rising edge detected in that same cycle is dropped. While `count_clear` = 0 the total keeps accumulating across gates and across mode changes.
- R7: The event total holds at 2^`EVENT_W`-1 and does not wrap. It is zero-extended to 32 bits in `res_a`.
- R8: `res_a` and `res_b` change only in the cycle in which `res_valid` is high.
- R9: A high level on the input adds one count per rising edge, however long it lasts. Falling edges add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Conditioned asynchronous input to measure |
| mode_count | input | 1 | 0 = frequency mode, 1 = counter mode; sampled at the gate's closing edge |
| count_clear | input | 1 | 1 = clear the event total, 0 = leave it |
| res_a | output | 32 | First result word |
| res_b | output | 32 | Second result word |
| res_valid | output | 1 | One-cycle pulse when both words have been refreshed |

## Verification
An input rising edge is detected two clock edges after it is applied. Detection is counted at the next edge. Both words then appear together one cycle after the gate's closing edge, coinciding with `res_valid`.

The bench drives each gate's pulses and clear strobe right after a `res_valid` pulse and finishes them well before the gate closes, so every edge falls inside the intended gate. The expected pair for that gate is queued at that point. The monitor compares the pair only at the negative edge where `res_valid` is high. At every other negative edge it confirms that the words are unchanged and that the pulses are `GATE_CYCLES` apart.

// File: rtl/em_pkg.sv
// Package em_pkg
// Shared widths and the result word type for the edge meter.
// Assumes all result words are the same width.
package em_pkg;
    localparam int RES_W = 32;
    typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/em_sync_edge.sv
// Module em_sync_edge
// Brings an asynchronous input into the clock domain through STAGES flops.
// Flags one cycle for each low-to-high transition of the synchronized value.
// Assumes the input stays at each level for at least two clock cycles.
module em_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    // shift the raw input through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], raw_in};
    end

    // rising edge seen when the newest synchronized bit is 1 and the older one is 0
    assign rise = chain[LAST-1] & ~chain[LAST];

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/em_gate_timer.sv
// Module em_gate_timer
// Free-running counter over GATE_CYCLES reference cycles.
// Pulses gate_end in the last cycle of each gate.
// Reports the ticks counted in the gate that is closing.
// Assumes GATE_CYCLES >= 2.
module em_gate_timer
    import em_pkg::*;
#(
    parameter int unsigned GATE_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end,
    output res_t gate_ticks
);
    localparam int TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] tick;

    // advance the tick count and wrap it at the end of the gate
    always_ff @(posedge clk) begin
        if (!rst_n)        tick <= '0;
        else if (gate_end) tick <= '0;
        else               tick <= tick + 1'b1;
    end

    // the gate closes on its last tick
    assign gate_end = (tick == LAST_TICK);

    // ticks elapsed in the gate, including the closing one
    assign gate_ticks = res_t'(tick) + res_t'(1);

    // R2
    gate_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |=> (tick == '0));
    // R2
    gate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_end && $past(rst_n)) |=> (tick == $past(tick) + 1'b1));
endmodule

// File: rtl/em_event_accum.sv
// Module em_event_accum
// Keeps two counts of detected edges:
//   - a per-gate window count, restarted after each gate;
//   - a saturating event total, cleared on request.
// Presents the next values of both, so the closing edge of a gate sees
// the edge detected in its own cycle.
module em_event_accum
    import em_pkg::*;
#(
    parameter int EVENT_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clear,
    input  logic gate_end,
    output res_t win_total,
    output res_t ev_total
);
    localparam logic [EVENT_W-1:0] EV_MAX = '1;

    res_t               win_cnt;
    logic [EVENT_W-1:0] ev_cnt;
    logic [EVENT_W-1:0] ev_next;

    // window total including this cycle's edge
    assign win_total = win_cnt + res_t'(rise);

    // event total next value: a clear wins, otherwise count up to the ceiling
    always_comb begin
        if (clear)                       ev_next = '0;
        else if (rise && ev_cnt != EV_MAX) ev_next = ev_cnt + 1'b1;
        else                             ev_next = ev_cnt;
    end

    assign ev_total = res_t'(ev_next);

    // window count restarts after each gate
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt <= '0;
        else if (gate_end) win_cnt <= '0;
        else               win_cnt <= win_total;
    end

    // event total register
    always_ff @(posedge clk) begin
        if (!rst_n) ev_cnt <= '0;
        else        ev_cnt <= ev_next;
    end

    // R3
    win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |=> (win_cnt == '0));
    // R6
    ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ev_cnt == '0));
    // R7
    ev_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cnt == EV_MAX && !clear) |=> (ev_cnt == EV_MAX));
endmodule

// File: rtl/edge_meter.sv
// Module edge_meter
// Top level of the frequency meter and event counter.
// At each gate end, both result words are loaded together according to
// mode_count:
//   - frequency mode: halved edge count, then reference ticks;
//   - counter mode: event total, then halved edge count.
// Assumes a conditioned input whose pulses last at least two cycles.
module edge_meter
    import em_pkg::*;
#(
    parameter int unsigned GATE_CYCLES = 100_000_000,
    parameter int          EVENT_W     = 32,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sig_in,
    input  logic        mode_count,
    input  logic        count_clear,
    output logic [31:0] res_a,
    output logic [31:0] res_b,
    output logic        res_valid
);
    logic rise;
    logic gate_end;
    res_t gate_ticks;
    res_t win_total;
    res_t ev_total;
    res_t freq_half;

    em_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (sig_in),
        .rise   (rise)
    );

    em_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_end   (gate_end),
        .gate_ticks (gate_ticks)
    );

    em_event_accum #(.EVENT_W(EVENT_W)) i_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .clear     (count_clear),
        .gate_end  (gate_end),
        .win_total (win_total),
        .ev_total  (ev_total)
    );

    // reported frequency is half the edge count
    assign freq_half = win_total >> 1;

    // load both words together at the gate end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_a     <= '0;
            res_b     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= gate_end;
            if (gate_end) begin
                res_a <= mode_count ? ev_total : freq_half;
                res_b <= mode_count ? freq_half : gate_ticks;
            end
        end
    end

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(rst_n)) |-> ($stable(res_a) && $stable(res_b)));
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: tb/test_edge_meter.sv
// Scoreboard bench for edge_meter.
// The driver runs one gate of stimulus at a time and queues the expected
// result pair for it. The monitor pops and compares a pair at each res_valid.
module test_edge_meter;
    localparam int unsigned GATE = 64;
    localparam int          EVW  = 6;
    localparam int          EVMAX = (1 << EVW) - 1;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        string       tag_a;
        string       tag_b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        mode_count = 1'b0;
    logic        count_clear = 1'b0;
    logic [31:0] res_a;
    logic [31:0] res_b;
    logic        res_valid;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    int   ev_exp = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    edge_meter #(.GATE_CYCLES(GATE), .EVENT_W(EVW), .SYNC_STAGES(2)) i_edge_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_in      (sig_in),
        .mode_count  (mode_count),
        .count_clear (count_clear),
        .res_a       (res_a),
        .res_b       (res_b),
        .res_valid   (res_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!res_valid);
    endtask

    // drive one gate: mode, optional clear, n two-cycle-wide pulses; queue expectation
    task automatic run_gate(input bit m, input bit clr, input int n,
                            input string ta, input string tb);
        exp_t e;
        mode_count = m;
        if (clr) begin
            count_clear = 1'b1;
            ev_exp = 0;
        end
        @(negedge clk);
        count_clear = 1'b0;
        for (int i = 0; i < n; i++) begin
            sig_in = 1'b1;
            repeat (2) @(negedge clk);
            sig_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        ev_exp = (ev_exp + n > EVMAX) ? EVMAX : ev_exp + n;
        e.a = m ? 32'(ev_exp) : 32'(n / 2);
        e.b = m ? 32'(n / 2) : 32'(GATE);
        e.tag_a = ta;
        e.tag_b = tb;
        sb.push_back(e);
    endtask

    // monitor: compare at each valid, confirm hold and gate spacing elsewhere
    initial begin
        logic [31:0] held_a, held_b;
        int  gap;
        bit  seen;
        bit  hold_bad;
        exp_t e;
        gap = 0;
        seen = 1'b0;
        hold_bad = 1'b0;
        held_a = '0;
        held_b = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            gap++;
            if (res_valid) begin
                if (seen) check("R2 gate spacing", 32'(gap), 32'(GATE));
                seen = 1'b1;
                gap = 0;
                // R8: words held between pulses
                check("R8 hold between pulses", 32'(hold_bad), 32'd0);
                hold_bad = 1'b0;
                if (sb.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R2 unexpected pulse actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    check(e.tag_a, res_a, e.a);
                    check(e.tag_b, res_b, e.b);
                end
                held_a = res_a;
                held_b = res_b;
            end else if (res_a !== held_a || res_b !== held_b) begin
                hold_bad = 1'b1;
            end
        end
    end

    // driver
    initial begin
        exp_t e0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_a reset", res_a, 32'd0);
        check("R1 res_b reset", res_b, 32'd0);
        check("R1 res_valid reset", 32'(res_valid), 32'd0);
        e0.a = 32'd0;
        e0.b = 32'(GATE);
        e0.tag_a = "R3 idle gate";
        e0.tag_b = "R4 idle ticks";
        sb.push_back(e0);
        rst_n = 1'b1;

        wait_valid(); run_gate(1'b0, 1'b0, 10, "R3 even edges", "R4 ticks");
        wait_valid(); run_gate(1'b0, 1'b0, 11, "R9 odd edges halved", "R4 ticks");
        wait_valid(); run_gate(1'b1, 1'b1, 7,  "R6 clear then count", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 12, "R6 accumulate", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 12, "R5 total", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 12, "R5 total", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 12, "R5 total", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 12, "R7 saturate", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b0, 5,  "R7 hold at max", "R5 freq word");
        wait_valid(); run_gate(1'b1, 1'b1, 0,  "R6 clear to zero", "R5 no edges");
        wait_valid(); run_gate(1'b0, 1'b0, 1,  "R3 single edge", "R4 ticks");
        wait_valid(); run_gate(1'b0, 1'b0, 12, "R3 many edges", "R4 ticks");
        wait_valid();
        @(negedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule